// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Timer

This block holds two 8-bit up-counters, a lower and an upper timer. Each timer has an 8-bit control register and an 8-bit compare register. The control register picks the count clock, the enable and the mode bits, and the upper one also holds the enable for the timer output pin. The count clock is either the system clock, a fixed division of it, or an external pin that is synchronised and divided in the system clock domain. The counters advance on one-cycle tick pulses and never run on a second clock.

The operating mode is decoded from the mode bits of both control registers taken together. In discrete mode each timer runs on its own. In cascade mode the two form one 16-bit counter, paced by the lower timer's clock select and compared against the two compare registers joined. Only the upper timer's enable bit starts and clears this counter. Carrier-generator and PWM codes are recognised but keep the block idle, like every prohibited code.

Top module: `dual_timer_top`

## Requirements
- R1: After reset both counts are 0, both match flags are 0 and the timer output is 0. Both control registers reset to 0x00 and both compare registers reset to 0xFF.
- R2: Control byte layout is: bit 7 enable, bits 5:3 clock select, bits 2:1 mode bits, bit 0 output enable. In discrete mode, a timer whose enable is 0 has a count of 0. A timer whose enable is 1 with clock select 000 counts up by one on every system clock cycle.
- R3: A timer counts up on each tick. When it ticks while its count equals its compare value, the count goes to 0 and its match flag is high for that one cycle.
- R4: Clock select 001 gives one tick every 4 system clock cycles.
- R5: Clock selects 010, 011, 100 and 101 tick once per rising edge of the synchronised external pin, once per 2 edges, once per 4 edges and once per 8 edges respectively.
- R6: Clock selects 110 and 111 give no ticks, so an enabled timer stays at 0.
- R7: The mode code is {lower bits 2:1, upper bits 2:1}. 0000 is discrete and 0101 is cascade. Every other code, including carrier (0011) and PWM (0010), holds both counts at 0 and drives the output low.
- R8: In cascade mode, {upper, lower} counts as one 16-bit value on the lower timer's ticks, and the lower count carries into the upper count. The count clears after a tick at {upper compare, lower compare}, and that match is signalled on the upper match flag.
- R9: In cascade mode, the upper enable alone starts and clears both counts. The lower enable bit has no effect.
- R10: While the upper output enable is 1, the timer output toggles one cycle after each upper match flag. While the upper output enable is 0, the timer output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External count clock pin, asynchronous |
| ctl_lo_we_i | input | 1 | Write strobe, lower control register |
| ctl_hi_we_i | input | 1 | Write strobe, upper control register |
| cmp_lo_we_i | input | 1 | Write strobe, lower compare register |
| cmp_hi_we_i | input | 1 | Write strobe, upper compare register |
| wdata_i | input | 8 | Write data for all four registers |
| cnt_lo_o | output | 8 | Lower count |
| cnt_hi_o | output | 8 | Upper count |
| match_lo_o | output | 1 | Lower compare-match pulse |
| match_hi_o | output | 1 | Upper (or 16-bit cascade) compare-match pulse |
| tout_o | output | 1 | Timer output pin |

## Verification
Several properties are checked on every cycle:
- A disabled or idle timer is cleared.
- A match flag always comes with a zero count.
- The cascade carry from 0xFF lands in the upper count.
- An enabled discrete timer without a tick holds its value.
- The external edge pulse lasts one cycle.
- The output falls after its enable is cleared.

Only the bench scenarios can show the exact counts for each clock source and divider ratio, the decode of every mode code, wrap-around at the compare value in both modes, that the lower enable has no effect in cascade mode, and the toggle phase of the output.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;

  typedef struct packed {
    logic       en;
    logic       rsv;
    logic [2:0] sel;
    logic [1:0] mode;
    logic       oe;
  } tmr_ctl_t;

  typedef enum logic [2:0] {
    MODE_DISC,
    MODE_CASC,
    MODE_CARRIER,
    MODE_PWM,
    MODE_BAD
  } tmr_mode_e;

  function automatic tmr_mode_e decode_mode(input logic [3:0] code);
    case (code)
      4'b0000: return MODE_DISC;
      4'b0101: return MODE_CASC;
      4'b0011: return MODE_CARRIER;
      4'b0010: return MODE_PWM;
      default: return MODE_BAD;
    endcase
  endfunction

endpackage

// File: rtl/dt_reg.sv
module dt_reg #(
  parameter int          W     = 8,
  parameter logic [W-1:0] RST  = '0,
  parameter logic [W-1:0] ZMASK = '0   // bits always stored as 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= d_i & ~ZMASK;
  end
endmodule

// File: rtl/dt_clk_src.sv
module dt_clk_src #(
  parameter int SYS_DIV_W = 2,
  parameter int EXT_DIV_W = 3,
  localparam int NSRC     = 3 + EXT_DIV_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_clk_i,
  output logic [NSRC-1:0] src_o
);
  logic [2:0]           sync_q;
  logic                 rise;
  logic [SYS_DIV_W-1:0] sdiv_q;
  logic [EXT_DIV_W-1:0] ediv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      sdiv_q <= '0;
      ediv_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], ext_clk_i};
      sdiv_q <= sdiv_q + 1'b1;
      if (rise) ediv_q <= ediv_q + 1'b1;
    end
  end

  assign rise     = sync_q[1] & ~sync_q[2];
  assign src_o[0] = 1'b1;
  assign src_o[1] = &sdiv_q;
  assign src_o[2] = rise;

  for (genvar k = 1; k <= EXT_DIV_W; k++) begin : g_ext_tap
    assign src_o[2+k] = rise & (&ediv_q[k-1:0]);
  end

  a_r5_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !rise);
endmodule

// File: rtl/dt_count_core.sv
module dt_count_core #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         disc_i,
  input  logic         casc_i,
  input  logic         en_lo_i,
  input  logic         en_hi_i,
  input  logic         tick_lo_i,
  input  logic         tick_hi_i,
  input  logic [W-1:0] cmp_lo_i,
  input  logic [W-1:0] cmp_hi_i,
  output logic [W-1:0] cnt_lo_o,
  output logic [W-1:0] cnt_hi_o,
  output logic         match_lo_o,
  output logic         match_hi_o
);
  localparam int W2 = 2 * W;

  logic [W-1:0]  lo_d, hi_d;
  logic          mlo_d, mhi_d;
  logic          lo_run, hi_run;
  logic [W2-1:0] cnt2, cmp2;

  assign lo_run = disc_i & en_lo_i;
  assign hi_run = (disc_i | casc_i) & en_hi_i;
  assign cnt2   = {cnt_hi_o, cnt_lo_o};
  assign cmp2   = {cmp_hi_i, cmp_lo_i};

  always_comb begin
    lo_d  = cnt_lo_o;
    hi_d  = cnt_hi_o;
    mlo_d = 1'b0;
    mhi_d = 1'b0;
    if (casc_i) begin
      if (!en_hi_i) begin
        lo_d = '0;
        hi_d = '0;
      end else if (tick_lo_i) begin
        if (cnt2 == cmp2) begin
          {hi_d, lo_d} = '0;
          mhi_d        = 1'b1;
        end else begin
          {hi_d, lo_d} = W2'(cnt2 + 1'b1);
        end
      end
    end else begin
      if (!lo_run) lo_d = '0;
      else if (tick_lo_i) begin
        if (cnt_lo_o == cmp_lo_i) begin
          lo_d  = '0;
          mlo_d = 1'b1;
        end else lo_d = W'(cnt_lo_o + 1'b1);
      end
      if (!hi_run) hi_d = '0;
      else if (tick_hi_i) begin
        if (cnt_hi_o == cmp_hi_i) begin
          hi_d  = '0;
          mhi_d = 1'b1;
        end else hi_d = W'(cnt_hi_o + 1'b1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_lo_o   <= '0;
      cnt_hi_o   <= '0;
      match_lo_o <= 1'b0;
      match_hi_o <= 1'b0;
    end else begin
      cnt_lo_o   <= lo_d;
      cnt_hi_o   <= hi_d;
      match_lo_o <= mlo_d;
      match_hi_o <= mhi_d;
    end
  end

  a_r2_hi_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_run |=> (cnt_hi_o == '0) && !match_hi_o);
  a_r2_lo_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lo_run || (casc_i && en_hi_i)) |=> (cnt_lo_o == '0) && !match_lo_o);
  a_r3_match_lo_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_lo_o |-> (cnt_lo_o == '0));
  a_r3_match_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_hi_o |-> (cnt_hi_o == '0) && (cnt_lo_o == '0 || !casc_i));
  a_r6_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disc_i && en_hi_i && !tick_hi_i) |=> $stable(cnt_hi_o));
  a_r8_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc_i && en_hi_i && tick_lo_i && cnt_lo_o == '1 && cnt2 != cmp2)
      |=> (cnt_lo_o == '0) && (cnt_hi_o == W'($past(cnt_hi_o) + 1'b1)));
  a_r9_casc_hi_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc_i && !en_hi_i) |=> (cnt_lo_o == '0) && (cnt_hi_o == '0));
endmodule

// File: rtl/dual_timer_top.sv
module dual_timer_top
  import dual_timer_pkg::*;
#(
  parameter int W         = 8,
  parameter int SYS_DIV_W = 2,
  parameter int EXT_DIV_W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ext_clk_i,
  input  logic         ctl_lo_we_i,
  input  logic         ctl_hi_we_i,
  input  logic         cmp_lo_we_i,
  input  logic         cmp_hi_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_lo_o,
  output logic [W-1:0] cnt_hi_o,
  output logic         match_lo_o,
  output logic         match_hi_o,
  output logic         tout_o
);
  localparam int NSRC  = 3 + EXT_DIV_W;
  localparam int SEL_W = 3;
  localparam int NPAD  = 2 ** SEL_W;

  tmr_ctl_t        ctl_lo, ctl_hi;
  logic [W-1:0]    cmp_lo, cmp_hi;
  logic [NSRC-1:0] src;
  logic [NPAD-1:0] src_pad;
  tmr_mode_e       mode;
  logic            disc, casc;

  dt_reg #(.W(8), .RST(8'h00), .ZMASK(8'h40)) u_ctl_lo (
    .clk_i, .rst_ni, .we_i(ctl_lo_we_i), .d_i(wdata_i[7:0]), .q_o(ctl_lo));
  dt_reg #(.W(8), .RST(8'h00), .ZMASK(8'h40)) u_ctl_hi (
    .clk_i, .rst_ni, .we_i(ctl_hi_we_i), .d_i(wdata_i[7:0]), .q_o(ctl_hi));
  dt_reg #(.W(W), .RST('1), .ZMASK('0)) u_cmp_lo (
    .clk_i, .rst_ni, .we_i(cmp_lo_we_i), .d_i(wdata_i), .q_o(cmp_lo));
  dt_reg #(.W(W), .RST('1), .ZMASK('0)) u_cmp_hi (
    .clk_i, .rst_ni, .we_i(cmp_hi_we_i), .d_i(wdata_i), .q_o(cmp_hi));

  dt_clk_src #(.SYS_DIV_W(SYS_DIV_W), .EXT_DIV_W(EXT_DIV_W)) u_src (
    .clk_i, .rst_ni, .ext_clk_i, .src_o(src));

  assign src_pad = NPAD'(src);   // unused select codes read 0
  assign mode    = decode_mode({ctl_lo.mode, ctl_hi.mode});
  assign disc    = (mode == MODE_DISC);
  assign casc    = (mode == MODE_CASC);

  dt_count_core #(.W(W)) u_core (
    .clk_i, .rst_ni,
    .disc_i(disc), .casc_i(casc),
    .en_lo_i(ctl_lo.en), .en_hi_i(ctl_hi.en),
    .tick_lo_i(src_pad[ctl_lo.sel]), .tick_hi_i(src_pad[ctl_hi.sel]),
    .cmp_lo_i(cmp_lo), .cmp_hi_i(cmp_hi),
    .cnt_lo_o, .cnt_hi_o, .match_lo_o, .match_hi_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        tout_o <= 1'b0;
    else if (!ctl_hi.oe || !(disc || casc)) tout_o <= 1'b0;
    else if (match_hi_o)                tout_o <= ~tout_o;
  end

  a_r10_tout_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_hi.oe |=> !tout_o);
  a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(disc || casc) |=> !tout_o && cnt_lo_o == '0 && cnt_hi_o == '0);
endmodule

// File: tb/sim_dual_timer_top.sv
module sim_dual_timer_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       ctl_lo_we = 1'b0, ctl_hi_we = 1'b0, cmp_lo_we = 1'b0, cmp_hi_we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] cnt_lo, cnt_hi;
  logic       match_lo, match_hi, tout;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  dual_timer_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk),
    .ctl_lo_we_i(ctl_lo_we), .ctl_hi_we_i(ctl_hi_we),
    .cmp_lo_we_i(cmp_lo_we), .cmp_hi_we_i(cmp_hi_we),
    .wdata_i(wdata), .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi),
    .match_lo_o(match_lo), .match_hi_o(match_hi), .tout_o(tout));

  // {req, lo_ctl, hi_ctl, cmp_lo, cmp_hi, cycles}
  localparam int NV = 10;
  localparam logic [51:0] VEC [NV] = '{
    {4'd2, 8'h80, 8'h80, 8'hFF, 8'hFF, 16'd10},
    {4'd2, 8'h80, 8'h00, 8'hFF, 8'hFF, 16'd20},
    {4'd3, 8'h80, 8'h80, 8'h04, 8'h06, 16'd12},
    {4'd8, 8'h02, 8'h82, 8'hFF, 8'hFF, 16'd300},
    {4'd9, 8'h82, 8'h02, 8'hFF, 8'hFF, 16'd30},
    {4'd8, 8'h02, 8'h82, 8'h05, 8'h01, 16'd300},
    {4'd7, 8'h80, 8'h86, 8'hFF, 8'hFF, 16'd10},
    {4'd7, 8'h80, 8'h84, 8'hFF, 8'hFF, 16'd10},
    {4'd7, 8'h82, 8'h80, 8'hFF, 8'hFF, 16'd10},
    {4'd9, 8'h82, 8'h82, 8'hFF, 8'hFF, 16'd5}
  };

  // Model for clock select 000; lower started one cycle before upper (R2, R3, R7, R8, R9)
  function automatic logic [15:0] model(input logic [7:0] lc, input logic [7:0] hc,
                                        input logic [7:0] cl, input logic [7:0] ch,
                                        input int n);
    logic [3:0] code = {lc[2:1], hc[2:1]};
    int lo = 0, hi = 0, v;
    if (code == 4'b0000) begin
      if (lc[7]) lo = (n + 1) % (int'(cl) + 1);
      if (hc[7]) hi = n % (int'(ch) + 1);
    end else if (code == 4'b0101 && hc[7]) begin
      v  = n % ({int'(ch), 8'h00} + int'(cl) + 1);
      lo = v % 256;
      hi = v / 256;
    end
    return {8'(hi), 8'(lo)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; register captured at the next posedge
  task automatic wr(input int which, input logic [7:0] d);
    wdata = d;
    case (which)
      0: ctl_lo_we = 1'b1;
      1: ctl_hi_we = 1'b1;
      2: cmp_lo_we = 1'b1;
      default: cmp_hi_we = 1'b1;
    endcase
    @(negedge clk);
    {ctl_lo_we, ctl_hi_we, cmp_lo_we, cmp_hi_we} = '0;
  endtask

  task automatic setup(input logic [7:0] lc, input logic [7:0] hc,
                       input logic [7:0] cl, input logic [7:0] ch);
    wr(1, 8'h00); wr(0, 8'h00);
    wr(2, cl); wr(3, ch);
    wr(0, lc); wr(1, hc);
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int mcount;
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt_lo", cnt_lo, 0);
    chk("R1 cnt_hi", cnt_hi, 0);
    chk("R1 match", {match_lo, match_hi}, 0);
    chk("R1 tout", tout, 0);

    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16]);
      repeat (int'(VEC[i][15:0])) @(negedge clk);
      e = model(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16],
                int'(VEC[i][15:0]));
      chk($sformatf("R%0d vec%0d lo", VEC[i][51:48], i), cnt_lo, e[7:0]);
      chk($sformatf("R%0d vec%0d hi", VEC[i][51:48], i), cnt_hi, e[15:8]);
    end

    // R2 disabling clears a running timer
    setup(8'h80, 8'h80, 8'hFF, 8'hFF);
    repeat (7) @(negedge clk);
    wr(1, 8'h00);
    repeat (3) @(negedge clk);
    chk("R2 cleared hi", cnt_hi, 0);

    // R3 match pulses, R10 output toggle
    setup(8'h00, 8'h81, 8'hFF, 8'h03);
    mcount = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (match_hi) mcount++;
    end
    chk("R3 match count", mcount, 3);
    chk("R10 tout after 3 matches", tout, 0);
    @(negedge clk);
    chk("R10 tout toggled", tout, 1);
    wr(1, 8'h80);
    @(negedge clk);
    chk("R10 tout disabled", tout, 0);

    // R4 system clock / 4
    setup(8'h00, 8'h88, 8'hFF, 8'hFF);
    repeat (40) @(negedge clk);
    chk("R4 div4", cnt_hi, 10);

    // R6 prohibited clock selects
    setup(8'h00, 8'hB0, 8'hFF, 8'hFF);
    repeat (20) @(negedge clk);
    chk("R6 sel110", cnt_hi, 0);
    setup(8'h00, 8'hB8, 8'hFF, 8'hFF);
    repeat (20) @(negedge clk);
    chk("R6 sel111", cnt_hi, 0);

    // R5 external pin sources
    setup(8'h00, 8'h90, 8'hFF, 8'hFF); pulses(6);
    chk("R5 ext", cnt_hi, 6);
    setup(8'h00, 8'h98, 8'hFF, 8'hFF); pulses(8);
    chk("R5 ext/2", cnt_hi, 4);
    setup(8'h00, 8'hA0, 8'hFF, 8'hFF); pulses(8);
    chk("R5 ext/4", cnt_hi, 2);
    setup(8'h00, 8'hA8, 8'hFF, 8'hFF); pulses(16);
    chk("R5 ext/8", cnt_hi, 2);

    // R8 cascade 16-bit match on upper flag
    setup(8'h02, 8'h82, 8'h02, 8'h01);
    mcount = 0;
    for (int i = 0; i < 259; i++) begin
      @(negedge clk);
      if (match_hi) mcount++;
      if (match_lo) mcount += 100;
    end
    chk("R8 cascade match", mcount, 1);
    chk("R8 cascade wrapped", {cnt_hi, cnt_lo}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule